// File: doc/BRIEF.md
# Synchronous Serial Absolute Encoder Reader

This block is the master side of a synchronous serial link to an absolute position encoder. It owns the clock line and listens on the data line. A host hands it one 32-bit request word naming how many bits to read and how long each clock half-period lasts in microseconds. The block then runs one complete frame. A falling clock edge tells the encoder to freeze its position. The data bits follow, one per clock cycle. The clock then sits idle long enough for the encoder's internal monoflop to time out.

When the frame ends, the block presents the assembled value, up to 64 bits wide, in two forms: as one word and as separate low and high 32-bit halves. It also reports how many microseconds the whole transaction took, and it pulses a done strobe. All timing is counted in microsecond ticks, which a prescaler derives from the system clock frequency given as a parameter. Line drivers and the host-side command handling sit outside the block.

Top module: `ssi_enc_master`

## Requirements
- R1: After reset, and at every cycle in which no frame is running, `ssi_clk_o` is 1, `busy` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A frame with an effective bit count n produces exactly n+1 falling edges on `ssi_clk_o`. The first is the latch edge. Every high and low phase lasts one half-period.
- R3: Data is sampled once per bit, when the clock falls. Bits enter MSB-first: each new bit shifts the value left and lands in bit 0. `rsp_lo` equals `rsp_value[31:0]` and `rsp_hi` equals `rsp_value[63:32]`.
- R4: After the last bit, the clock goes high and stays high for exactly 30 microseconds before `rsp_done` rises.
- R5: `rsp_dur_us` equals h*(2n+1)+30, the number of microseconds from request acceptance to completion, where h is the effective half-period.
- R6: Request word fields: bit count in [31:24], half-period in [23:8]. Bits [7:0] have no effect on the frame or its result.
- R7: A bit count of 0 still produces the latch edge and the 30 microsecond recovery, and it returns a value of 0.
- R8: A bit count above 64 is treated as 64.
- R9: `busy` is high from the cycle after acceptance until the cycle `rsp_done` rises. While busy, `req_ready` is 0 and `req_valid` is ignored.
- R10: The value is cleared at the start of every frame, so bits left over from an earlier, longer frame never appear in the result.
- R11: A half-period field of 0 is run as 1 microsecond.
- R12: `rsp_done` is a single-cycle pulse. `rsp_value`, `rsp_lo`, `rsp_hi` and `rsp_dur_us` hold their values until the next `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request word is offered |
| req_ready | output | 1 | Block can accept a request |
| req_word | input | 32 | Bit count [31:24], half-period in microseconds [23:8], [7:0] unused |
| ssi_clk_o | output | 1 | Serial clock to the encoder, idles high |
| ssi_data_i | input | 1 | Serial data from the encoder, asynchronous |
| busy | output | 1 | Frame in progress |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_value | output | 64 | Assembled position value |
| rsp_lo | output | 32 | Low half of the value |
| rsp_hi | output | 32 | High half of the value |
| rsp_dur_us | output | 32 | Transaction time in microseconds |

## Verification
The bench builds the block with a system clock frequency parameter of 4 MHz, so one microsecond is only four clock cycles. This makes full 64-bit frames, the 30 microsecond recovery and bit counts well above 64 cheap to run. Because the prescaler restarts on acceptance, the gap between the last rising clock edge and done can be checked to the exact cycle (120), and the reported duration can be checked as an exact number. A behavioural encoder in the bench shifts a known pattern out on rising edges, so the assembled value, both halves and the falling-edge count are all predictable for every bit count and half-period tried.

// File: rtl/ssi_enc_pkg.sv
`timescale 1ns/1ps
package ssi_enc_pkg;
  localparam int VAL_W    = 64;
  localparam int CNT_W    = $clog2(VAL_W) + 1;
  localparam int HALF_W   = 16;
  localparam int REQ_W    = 32;
  localparam int NBITS_LO = 24;
  localparam int HALF_LO  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_HIGH,
    ST_LOW,
    ST_RECOV
  } frame_st_t;

  function automatic logic [CNT_W-1:0] clamp_count(input logic [7:0] f);
    if (f > 8'(VAL_W)) return CNT_W'(VAL_W);
    return f[CNT_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] fix_half(input logic [HALF_W-1:0] f);
    return (f == '0) ? HALF_W'(1) : f;
  endfunction
endpackage

// File: rtl/ssi_us_tick.sv
`timescale 1ns/1ps
module ssi_us_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_cnt
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || clr)                cnt <= '0;
        else if (cnt == CW'(DIV - 1))  cnt <= '0;
        else                           cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == CW'(DIV - 1));

      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ssi_sync2.sv
`timescale 1ns/1ps
module ssi_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] s;

  always_ff @(posedge clk) begin
    if (rst) s <= '1;
    else     s <= {s[STAGES-2:0], d};
  end

  assign q = s[STAGES-1];
endmodule

// File: rtl/ssi_frame_ctrl.sv
`timescale 1ns/1ps
module ssi_frame_ctrl
  import ssi_enc_pkg::*;
#(
  parameter int REC_US = 30,
  parameter int DUR_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             data_s,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_word,
  output logic             req_ready,
  output logic             accept,
  output logic             busy,
  output logic             sclk,
  output logic             done,
  output logic [VAL_W-1:0] value,
  output logic [DUR_W-1:0] dur_us
);
  frame_st_t         st;
  logic [CNT_W-1:0]  bits_left;
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] wcnt;
  logic [HALF_W-1:0] target;
  logic [VAL_W-1:0]  shreg;
  logic [DUR_W-1:0]  dur_cnt;
  logic              end_wait;
  logic              rsv_unused;

  assign rsv_unused = ^req_word[HALF_LO-1:0];
  assign req_ready  = (st == ST_IDLE);
  assign busy       = (st != ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign target     = (st == ST_RECOV) ? HALF_W'(REC_US) : half_q;
  assign end_wait   = tick && (wcnt == target - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sclk      <= 1'b1;
      bits_left <= '0;
      half_q    <= HALF_W'(1);
      wcnt      <= '0;
      shreg     <= '0;
      dur_cnt   <= '0;
      done      <= 1'b0;
      value     <= '0;
      dur_us    <= '0;
    end else begin
      done <= 1'b0;
      if (busy && tick) begin
        dur_cnt <= dur_cnt + DUR_W'(1);
        wcnt    <= end_wait ? '0 : wcnt + HALF_W'(1);
      end
      case (st)
        ST_IDLE: if (req_valid) begin
          st        <= ST_LATCH;
          sclk      <= 1'b0;
          shreg     <= '0;
          dur_cnt   <= '0;
          wcnt      <= '0;
          bits_left <= clamp_count(req_word[NBITS_LO +: 8]);
          half_q    <= fix_half(req_word[HALF_LO +: HALF_W]);
        end
        ST_LATCH: if (end_wait) begin
          sclk <= 1'b1;
          st   <= (bits_left == '0) ? ST_RECOV : ST_HIGH;
        end
        ST_HIGH: if (end_wait) begin
          sclk  <= 1'b0;
          shreg <= {shreg[VAL_W-2:0], data_s};
          st    <= ST_LOW;
        end
        ST_LOW: if (end_wait) begin
          sclk      <= 1'b1;
          bits_left <= bits_left - CNT_W'(1);
          st        <= (bits_left == CNT_W'(1)) ? ST_RECOV : ST_HIGH;
        end
        ST_RECOV: if (end_wait) begin
          st     <= ST_IDLE;
          done   <= 1'b1;
          value  <= shreg;
          dur_us <= dur_cnt + DUR_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  bits_range_chk: assert property (@(posedge clk) disable iff (rst)
    bits_left <= CNT_W'(VAL_W));

  // R2
  latch_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH) |-> !sclk);
endmodule

// File: rtl/ssi_enc_master.sv
`timescale 1ns/1ps
module ssi_enc_master
  import ssi_enc_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int REC_US      = 30,
  parameter int DUR_W       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [REQ_W-1:0] req_word,
  output logic             ssi_clk_o,
  input  logic             ssi_data_i,
  output logic             busy,
  output logic             rsp_done,
  output logic [VAL_W-1:0] rsp_value,
  output logic [31:0]      rsp_lo,
  output logic [31:0]      rsp_hi,
  output logic [DUR_W-1:0] rsp_dur_us
);
  localparam int TICK_DIV = CLK_FREQ_HZ / 1_000_000;

  logic tick;
  logic accept;
  logic data_s;

  ssi_us_tick #(.DIV(TICK_DIV)) tick_i (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .tick(tick)
  );

  ssi_sync2 #(.STAGES(2)) sync_i (
    .clk(clk),
    .rst(rst),
    .d  (ssi_data_i),
    .q  (data_s)
  );

  ssi_frame_ctrl #(.REC_US(REC_US), .DUR_W(DUR_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .data_s   (data_s),
    .req_valid(req_valid),
    .req_word (req_word),
    .req_ready(req_ready),
    .accept   (accept),
    .busy     (busy),
    .sclk     (ssi_clk_o),
    .done     (rsp_done),
    .value    (rsp_value),
    .dur_us   (rsp_dur_us)
  );

  assign rsp_lo = rsp_value[31:0];
  assign rsp_hi = rsp_value[63:32];

  // R1
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ssi_clk_o);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(busy));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_done |-> ($stable(rsp_value) && $stable(rsp_dur_us)));
endmodule

// File: tb/ssi_enc_master_tb_top.sv
`timescale 1ns/1ps
module ssi_enc_master_tb_top;
  localparam int FREQ = 4_000_000;
  localparam int CPU  = 4;
  localparam int REC  = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_word = '0;
  logic        ssi_clk_o;
  logic        ssi_data_i = 1'b1;
  logic        busy;
  logic        rsp_done;
  logic [63:0] rsp_value;
  logic [31:0] rsp_lo, rsp_hi, rsp_dur_us;

  always #4 clk = ~clk;

  ssi_enc_master #(.CLK_FREQ_HZ(FREQ), .REC_US(REC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .ssi_clk_o(ssi_clk_o), .ssi_data_i(ssi_data_i),
    .busy(busy), .rsp_done(rsp_done), .rsp_value(rsp_value),
    .rsp_lo(rsp_lo), .rsp_hi(rsp_hi), .rsp_dur_us(rsp_dur_us)
  );

  int checks = 0;
  int fails  = 0;

  // encoder model: shifts the pattern out MSB-first on rising clock edges
  logic [63:0] enc_pat = '0;
  int          enc_idx = 64;
  always @(posedge ssi_clk_o) begin
    #1;
    if (enc_idx < 64) ssi_data_i = enc_pat[63 - enc_idx];
    else              ssi_data_i = 1'b1;
    enc_idx++;
  end

  // line monitor, sampled 2 ns after each rising system clock edge
  int   cyc = 0, falls = 0, last_rise = 0, done_cyc = 0, done_cnt = 0;
  logic prev_s = 1'b1;
  always @(posedge clk) begin
    #2;
    cyc++;
    if (ssi_clk_o === 1'b1 && prev_s === 1'b0) last_rise = cyc;
    if (ssi_clk_o === 1'b0 && prev_s === 1'b1) falls++;
    prev_s = ssi_clk_o;
    if (rsp_done === 1'b1) begin
      done_cyc = cyc;
      done_cnt++;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_word  = w;
    @(negedge clk);
    req_valid = 1'b0;
    req_word  = '0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (rsp_done) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic run_frame(input string tag, input int bits_f, input int half_f,
                           input logic [7:0] rsv, input logic [63:0] pat);
    int          n, h, f0, d0;
    logic [63:0] expv;
    bit          ok;
    n    = (bits_f > 64) ? 64 : bits_f;
    h    = (half_f == 0) ? 1 : half_f;
    expv = (n == 0) ? 64'd0 : (pat >> (64 - n));
    @(negedge clk);
    enc_pat = pat;
    enc_idx = 0;
    f0 = falls;
    d0 = done_cnt;
    send({bits_f[7:0], half_f[15:0], rsv});
    chk({tag, " R9"}, "busy after accept", 64'(busy), 64'd1);
    chk({tag, " R9"}, "ready while busy", 64'(req_ready), 64'd0);
    wait_done(ok);
    chk({tag, " R12"}, "done seen", 64'(ok), 64'd1);
    chk({tag, " R3"}, "value", rsp_value, expv);
    chk({tag, " R3"}, "low word", 64'(rsp_lo), 64'(expv[31:0]));
    chk({tag, " R3"}, "high word", 64'(rsp_hi), 64'(expv[63:32]));
    chk({tag, " R5"}, "duration", 64'(rsp_dur_us), 64'(h * (2 * n + 1) + REC));
    chk({tag, " R2"}, "falling edges", 64'(falls - f0), 64'(n + 1));
    chk({tag, " R4"}, "recovery cycles", 64'(done_cyc - last_rise), 64'(REC * CPU));
    chk({tag, " R9"}, "busy at done", 64'(busy), 64'd0);
    chk({tag, " R1"}, "clock idle", 64'(ssi_clk_o), 64'd1);
    chk({tag, " R12"}, "one done pulse", 64'(done_cnt - d0), 64'd1);
  endtask

  task automatic t_reset();
    chk("R1", "clock after reset", 64'(ssi_clk_o), 64'd1);
    chk("R1", "busy after reset", 64'(busy), 64'd0);
    chk("R1", "ready after reset", 64'(req_ready), 64'd1);
    chk("R12", "done after reset", 64'(rsp_done), 64'd0);
  endtask

  task automatic t_refuse();
    logic [63:0] pa;
    int          d0;
    bit          ok;
    bit          seen_ready;
    pa = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    enc_pat = pa;
    enc_idx = 0;
    d0 = done_cnt;
    send({8'd16, 16'd2, 8'd0});
    seen_ready = 1'b0;
    for (int i = 0; i < 30; i++) begin
      req_valid = 1'b1;
      req_word  = {8'd40, 16'd1, 8'd0};
      @(negedge clk);
      if (req_ready) seen_ready = 1'b1;
    end
    req_valid = 1'b0;
    req_word  = '0;
    chk("R9", "ready during busy", 64'(seen_ready), 64'd0);
    wait_done(ok);
    chk("R9", "first frame result", rsp_value, 64'h1234);
    chk("R9", "first frame duration", 64'(rsp_dur_us), 64'(2 * 33 + REC));
    repeat (60) @(negedge clk);
    chk("R9", "no second frame", 64'(busy), 64'd0);
    chk("R12", "done count", 64'(done_cnt - d0), 64'd1);
    chk("R12", "value held", rsp_value, 64'h1234);
    chk("R12", "duration held", 64'(rsp_dur_us), 64'(2 * 33 + REC));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // R2 R3 R4 R5 basic 8-bit frame
    run_frame("R2", 8, 2, 8'h00, 64'hA500_0000_0000_0000);
    // R3 full width, both halves
    run_frame("R3", 64, 1, 8'h00, 64'hDEAD_BEEF_0123_4567);
    // R6 reserved byte set, must match the clean result
    run_frame("R6", 12, 3, 8'hFF, 64'hC3A0_0000_0000_0000);
    // R7 R10 zero-bit frame after a nonzero result
    run_frame("R7", 0, 2, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    // R8 count of 200 treated as 64
    run_frame("R8", 200, 1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    // R10 R11 short frame after all-ones, half-period field 0
    run_frame("R10", 4, 0, 8'h00, 64'h5000_0000_0000_0000);
    run_frame("R11", 5, 0, 8'h5A, 64'h9800_0000_0000_0000);
    t_refuse();
    finish_run();
  end
endmodule